// File: doc/BRIEF.md
# Byte-Framed Three-Wire EEPROM Master

This block talks to a serial three-wire EEPROM (chip select, serial clock, data in, data out) organised as 16-bit words. It uses only whole 8-bit shift frames, the way a byte-oriented SPI engine works. The user side presents an operation (read a run of words, write one word, or enable writes), a word address and a word count, and for a write also the data word. Read words come back as 16-bit values, each with a one-cycle valid strobe. A done pulse marks the end of the operation.

The device ignores zero bits until it sees a start bit. The master uses this to pad every command with leading zeros to exactly 16 clocks. For reads, the last of those 16 clocks lines up with the single zero the device emits before its first data bit. Every read data word therefore falls on a byte boundary and needs no bit realignment.

The serial clock idles low. Its half period is set at run time by a divider value. Chip select stays asserted for the whole operation. After it is released, it stays low for at least one full serial clock period before the next operation can raise it.

Top module: `mw_byte_master`

## Requirements
- R1: After reset `mw_cs`, `mw_sk`, `busy`, `rd_valid` and `done` are all 0.
- R2: `mw_sk` is low whenever `mw_cs` is low. Each half period of `mw_sk` lasts `clk_div`+1 clock cycles, so rising edges are 2*(`clk_div`+1) cycles apart. `mw_di` changes only while `mw_sk` is low, so it is stable at every rising edge.
- R3: A read (`cmd_op` = 0) shifts out, MSB first, the 16-bit command formed by six zeros, a one, the pair 1,0, the six address bits and a trailing zero. This is 0x0300 | (addr << 1).
- R4: A write (`cmd_op` = 1) shifts out seven zeros, a one, the pair 0,1 and the six address bits (0x0140 | addr). It then shifts out the 16-bit `cmd_wdata`, MSB first, for 32 serial clocks in total.
- R5: A write-enable (`cmd_op` = 2 or 3) shifts out seven zeros, a one, the pair 0,0, then 1,1 and four zeros (0x0130), for 16 serial clocks in total.
- R6: Chip select is held from the first command bit to the last data bit. The number of serial clock rising edges inside one chip-select window is always a multiple of 8: 16 + 16*N for a read of N words.
- R7: A read returns N words from consecutive addresses, wrapping from 63 to 0. Each word is built from two received bytes, high byte first, from the bit sampled on `mw_do` at each rising edge. Each word is presented on `rd_data` with a one-cycle `rd_valid` pulse. `mw_di` is 0 throughout the read data phase.
- R8: `busy` is 1 from the cycle after an operation is accepted until `done` pulses. `done` is a single-cycle pulse, issued with chip select already low and `busy` already 0.
- R9: Between the fall of `mw_cs` and its next rise there are at least 2*(`clk_div`+1) clock cycles.
- R10: `cmd_valid` is ignored while `busy` is 1. The running operation keeps its length and output, and no further operation starts afterwards.
- R11: A read with a word count of 0 behaves as a read of one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Start an operation (taken when idle) |
| cmd_op | input | 2 | 0 read, 1 write, 2 or 3 write-enable |
| cmd_addr | input | ADDR_W | Word address |
| cmd_words | input | CNT_W | Number of words to read (0 means 1) |
| cmd_wdata | input | WORD_W | Word to write |
| clk_div | input | DIV_W | Serial clock half period minus one, in clock cycles |
| busy | output | 1 | Operation in progress |
| rd_data | output | WORD_W | Read word |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| done | output | 1 | One-cycle pulse at the end of an operation |
| mw_cs | output | 1 | Device chip select, active high |
| mw_sk | output | 1 | Device serial clock |
| mw_di | output | 1 | Serial data to the device |
| mw_do | input | 1 | Serial data from the device |

## Verification
The bench builds the block with a 4-bit divider and a 4-bit word count, keeping the address at 6 bits and the word at 16. The narrow divider lets divider values 0 to 3 cover both the fastest serial clock and a stretched one within a short run. The narrow count makes a 15-word read and the zero-count case cheap to reach. A wrap-around read from address 62 and a read run across a freshly written word exercise the automatic address advance in the device model against the word-aligned capture.

// File: rtl/mwbm_pkg.sv
package mwbm_pkg;

   localparam int FRAME_BITS = 8;
   localparam int CMD_FRAMES = 2;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_WREN  = 2'd2
   } mw_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_GAP   = 2'd2
   } mw_state_e;

endpackage

// File: rtl/mwbm_clkdiv.sv
module mwbm_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (cnt == div) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == div);

endmodule

// File: rtl/mwbm_shifter.sv
module mwbm_shifter #(
   parameter int FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_byte,
   input  logic               rise,
   input  logic               q_in,
   output logic               tx_msb,
   output logic [FRAME_W-1:0] rx_byte
);

   logic [FRAME_W-1:0] tx_q;
   logic [FRAME_W-1:0] rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
         rx_q <= '0;
      end else begin
         if (load)      tx_q <= load_byte;
         else if (rise) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
         if (rise)      rx_q <= {rx_q[FRAME_W-2:0], q_in};
      end
   end

   assign tx_msb  = tx_q[FRAME_W-1];
   assign rx_byte = rx_q;

endmodule

// File: rtl/mwbm_word_pack.sv
module mwbm_word_pack #(
   parameter int FRAME_W     = 8,
   parameter int WORD_FRAMES = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           clear,
   input  logic                           strobe,
   input  logic [FRAME_W-1:0]             byte_in,
   output logic [FRAME_W*WORD_FRAMES-1:0] word,
   output logic                           valid
);

   localparam int WORD_W = FRAME_W * WORD_FRAMES;

   generate
      if (WORD_FRAMES == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word  <= '0;
               valid <= 1'b0;
            end else begin
               valid <= strobe && !clear;
               if (strobe) word <= byte_in;
            end
         end
      end else begin : g_accum
         localparam int CW = $clog2(WORD_FRAMES);
         logic [WORD_W-FRAME_W-1:0] acc;
         logic [CW-1:0]             cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc   <= '0;
               cnt   <= '0;
               word  <= '0;
               valid <= 1'b0;
            end else begin
               valid <= 1'b0;
               if (clear) begin
                  cnt <= '0;
               end else if (strobe) begin
                  if (cnt == CW'(WORD_FRAMES - 1)) begin
                     word  <= {acc, byte_in};
                     valid <= 1'b1;
                     cnt   <= '0;
                  end else begin
                     acc <= (WORD_W-FRAME_W)'({acc, byte_in});
                     cnt <= cnt + 1'b1;
                  end
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/mw_byte_master.sv
module mw_byte_master
   import mwbm_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int CNT_W  = 8,
   parameter int ADDR_W = 6,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [CNT_W-1:0]  cmd_words,
   input  logic [WORD_W-1:0] cmd_wdata,
   input  logic [DIV_W-1:0]  clk_div,
   output logic              busy,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              done,
   output logic              mw_cs,
   output logic              mw_sk,
   output logic              mw_di,
   input  logic              mw_do
);

   localparam int FRAME_W     = FRAME_BITS;
   localparam int WORD_FRAMES = WORD_W / FRAME_W;
   localparam int CMD_W       = CMD_FRAMES * FRAME_W;
   localparam int FIDX_W      = CNT_W + $clog2(WORD_FRAMES + 1) + 2;
   localparam int BCNT_W      = $clog2(FRAME_W + 1);

   generate
      if ((WORD_W % FRAME_W) != 0 || WORD_W < FRAME_W) begin : g_bad_word
         $error("WORD_W must be a nonzero multiple of the frame width");
      end
      if (ADDR_W < 2 || ADDR_W > CMD_W - 4) begin : g_bad_addr
         $error("ADDR_W must leave room for start, opcode and dummy bits");
      end
      if (DIV_W < 1 || CNT_W < 1) begin : g_bad_cnt
         $error("DIV_W and CNT_W must be at least 1");
      end
   endgenerate

   mw_state_e         state;
   logic [1:0]        op_q;
   logic [CMD_W-1:0]  cmd_q;
   logic [WORD_W-1:0] wdat_q;
   logic [FIDX_W-1:0] last_q, fidx, fnext, last_frame;
   logic [BCNT_W-1:0] bitcnt;
   logic              sk_q, cs_q, di_q, gap_q, done_q;
   logic              tick, rise, frame_end, accept, tx_msb;
   logic [CMD_W-1:0]  cmd_word;
   logic [CNT_W-1:0]  nwords;
   logic [FRAME_W-1:0] nxt_byte, rx_byte, load_byte;

   // command word: leading zeros fill the frame, read carries the dummy slot
   always_comb begin
      case (cmd_op)
         OP_READ:  cmd_word = CMD_W'({3'b110, cmd_addr, 1'b0});
         OP_WRITE: cmd_word = CMD_W'({3'b101, cmd_addr});
         default:  cmd_word = CMD_W'({3'b100, 2'b11, {(ADDR_W-2){1'b0}}});
      endcase
   end

   assign nwords = (cmd_words == '0) ? CNT_W'(1) : cmd_words;

   always_comb begin
      case (cmd_op)
         OP_READ:  last_frame = FIDX_W'(CMD_FRAMES - 1) + FIDX_W'(nwords) * FIDX_W'(WORD_FRAMES);
         OP_WRITE: last_frame = FIDX_W'(CMD_FRAMES + WORD_FRAMES - 1);
         default:  last_frame = FIDX_W'(CMD_FRAMES - 1);
      endcase
   end

   assign fnext = fidx + 1'b1;

   always_comb begin
      int sh;
      nxt_byte = '0;
      sh       = 0;
      if (fnext < FIDX_W'(CMD_FRAMES)) begin
         sh       = (CMD_FRAMES - 1 - int'(fnext)) * FRAME_W;
         nxt_byte = FRAME_W'(cmd_q >> sh);
      end else if (op_q == OP_WRITE) begin
         sh       = (WORD_FRAMES - 1 - (int'(fnext) - CMD_FRAMES)) * FRAME_W;
         nxt_byte = FRAME_W'(wdat_q >> sh);
      end
   end

   assign accept    = (state == ST_IDLE) && cmd_valid;
   assign rise      = (state == ST_SHIFT) && tick && !sk_q;
   assign frame_end = (state == ST_SHIFT) && tick && sk_q && (bitcnt == BCNT_W'(FRAME_W));
   assign load_byte = accept ? cmd_word[CMD_W-1 -: FRAME_W] : nxt_byte;

   mwbm_clkdiv #(.DIV_W(DIV_W)) i_clkdiv (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (state != ST_IDLE),
      .div  (clk_div),
      .tick (tick)
   );

   mwbm_shifter #(.FRAME_W(FRAME_W)) i_shifter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept || (frame_end && (fidx != last_q))),
      .load_byte(load_byte),
      .rise     (rise),
      .q_in     (mw_do),
      .tx_msb   (tx_msb),
      .rx_byte  (rx_byte)
   );

   mwbm_word_pack #(.FRAME_W(FRAME_W), .WORD_FRAMES(WORD_FRAMES)) i_pack (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (accept),
      .strobe (frame_end && (op_q == OP_READ) && (fidx >= FIDX_W'(CMD_FRAMES))),
      .byte_in(rx_byte),
      .word   (rd_data),
      .valid  (rd_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         op_q   <= '0;
         cmd_q  <= '0;
         wdat_q <= '0;
         last_q <= '0;
         fidx   <= '0;
         bitcnt <= '0;
         sk_q   <= 1'b0;
         cs_q   <= 1'b0;
         di_q   <= 1'b0;
         gap_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (cmd_valid) begin
                  state  <= ST_SHIFT;
                  op_q   <= cmd_op;
                  cmd_q  <= cmd_word;
                  wdat_q <= cmd_wdata;
                  last_q <= last_frame;
                  fidx   <= '0;
                  bitcnt <= '0;
                  sk_q   <= 1'b0;
                  cs_q   <= 1'b1;
                  di_q   <= cmd_word[CMD_W-1];
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (!sk_q) begin
                     sk_q   <= 1'b1;
                     bitcnt <= bitcnt + 1'b1;
                  end else begin
                     sk_q <= 1'b0;
                     if (bitcnt == BCNT_W'(FRAME_W)) begin
                        bitcnt <= '0;
                        if (fidx == last_q) begin
                           cs_q  <= 1'b0;
                           di_q  <= 1'b0;
                           gap_q <= 1'b0;
                           state <= ST_GAP;
                        end else begin
                           fidx <= fnext;
                           di_q <= nxt_byte[FRAME_W-1];
                        end
                     end else begin
                        di_q <= tx_msb;
                     end
                  end
               end
            end
            ST_GAP: begin
               if (tick) begin
                  gap_q <= 1'b1;
                  if (gap_q) begin
                     state  <= ST_IDLE;
                     done_q <= 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy  = (state != ST_IDLE);
   assign done  = done_q;
   assign mw_cs = cs_q;
   assign mw_sk = sk_q;
   assign mw_di = di_q;

endmodule

// File: rtl/mwbm_checker.sv
module mwbm_checker #(
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mw_cs,
   input logic             mw_sk,
   input logic             mw_di,
   input logic             rd_valid,
   input logic             done,
   input logic             busy,
   input logic [DIV_W-1:0] clk_div
);

   localparam int LOW_W = DIV_W + 3;

   logic [LOW_W-1:0] low_cnt;
   logic [2:0]       rise_mod;
   logic             sk_d;
   logic [LOW_W-1:0] gap_min;

   assign gap_min = LOW_W'({clk_div, 1'b0}) + LOW_W'(2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt  <= '1;
         rise_mod <= '0;
         sk_d     <= 1'b0;
      end else begin
         sk_d <= mw_sk;
         if (mw_cs)               low_cnt <= '0;
         else if (low_cnt != '1)  low_cnt <= low_cnt + 1'b1;
         if (!mw_cs)              rise_mod <= '0;
         else if (mw_sk && !sk_d) rise_mod <= rise_mod + 1'b1;
      end
   end

   AST_SK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !mw_cs |-> !mw_sk) else $error("sk high outside chip select"); // R2

   AST_DI_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mw_sk) |-> $stable(mw_di)) else $error("di moved at sk rise"); // R2

   AST_WHOLE_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mw_cs) |-> (rise_mod == 3'd0)) else $error("partial frame"); // R6

   AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mw_cs) |-> (low_cnt >= gap_min)) else $error("cs gap too short"); // R9

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid) else $error("rd_valid wider than one cycle"); // R7

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !mw_cs)) else $error("done while active"); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done wider than one cycle"); // R8

endmodule

bind mw_byte_master mwbm_checker #(.DIV_W(DIV_W)) i_mwbm_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .mw_cs   (mw_cs),
   .mw_sk   (mw_sk),
   .mw_di   (mw_di),
   .rd_valid(rd_valid),
   .done    (done),
   .busy    (busy),
   .clk_div (clk_div)
);

// File: tb/test_mw_byte_master.sv
`timescale 1ns/1ps
module test_mw_byte_master;

   localparam int DIV_W  = 4;
   localparam int CNT_W  = 4;
   localparam int ADDR_W = 6;
   localparam int WORD_W = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic [1:0]        cmd_op = '0;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic [CNT_W-1:0]  cmd_words = '0;
   logic [WORD_W-1:0] cmd_wdata = '0;
   logic [DIV_W-1:0]  clk_div = '0;
   logic              busy, rd_valid, done, mw_cs, mw_sk, mw_di, mw_do;
   logic [WORD_W-1:0] rd_data;

   mw_byte_master #(.DIV_W(DIV_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W))
   i_mw_byte_master (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_words(cmd_words), .cmd_wdata(cmd_wdata),
      .clk_div(clk_div), .busy(busy), .rd_data(rd_data), .rd_valid(rd_valid),
      .done(done), .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(mw_do)
   );

   always #5 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;
   logic [15:0] exp_q[$];
   logic [15:0] ref_mem[64];
   bit          ref_wen = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ---------------- device model ----------------
   logic [15:0] dv_mem[64];
   logic [5:0]  dv_addr;
   logic [7:0]  dv_hdr;
   logic [15:0] dv_sh, dv_wd;
   int          dv_st = 0, dv_bc = 0;
   bit          dv_wen = 1'b0;
   logic        dv_q = 1'b0;
   int          rec_n = 0;
   logic [63:0] rec_bits = '0;
   logic [15:0] rec_cmd = '0;
   bit          data_one = 1'b0;
   realtime     fall_t = 0, prev_t = 0, gap_ns = 1.0e9, period_ns = 0;
   bit          have_prev = 1'b0;

   assign mw_do = dv_q;

   always @(posedge mw_sk or negedge mw_cs or posedge mw_cs) begin
      if (!mw_cs) begin
         if (dv_st == 4 && dv_wen) dv_mem[dv_addr] = dv_wd;
         dv_st  = 0;
         fall_t = $realtime;
      end else if (!mw_sk) begin
         rec_n = 0; rec_bits = '0; rec_cmd = '0; data_one = 1'b0;
         gap_ns = $realtime - fall_t; dv_st = 0; have_prev = 1'b0;
      end else begin
         rec_n++;
         rec_bits = {rec_bits[62:0], mw_di};
         if (rec_n <= 16) rec_cmd = {rec_cmd[14:0], mw_di};
         else if (mw_di)  data_one = 1'b1;
         if (have_prev) period_ns = $realtime - prev_t;
         prev_t = $realtime; have_prev = 1'b1;
         case (dv_st)
            0: if (mw_di) begin dv_st = 1; dv_bc = 0; dv_hdr = '0; end
            1: begin
               dv_hdr = {dv_hdr[6:0], mw_di};
               dv_bc++;
               if (dv_bc == 8) begin
                  dv_addr = dv_hdr[5:0];
                  case (dv_hdr[7:6])
                     2'b10: begin dv_q <= 1'b0; dv_sh = dv_mem[dv_addr]; dv_bc = 0; dv_st = 2; end
                     2'b01: begin dv_bc = 0; dv_st = 3; end
                     2'b00: begin if (dv_hdr[5:4] == 2'b11) dv_wen = 1'b1; dv_st = 5; end
                     default: dv_st = 5;
                  endcase
               end
            end
            2: begin
               dv_q <= dv_sh[15];
               dv_sh = {dv_sh[14:0], 1'b0};
               dv_bc++;
               if (dv_bc == 16) begin dv_addr = dv_addr + 1'b1; dv_sh = dv_mem[dv_addr]; dv_bc = 0; end
            end
            3: begin
               dv_wd = {dv_wd[14:0], mw_di};
               dv_bc++;
               if (dv_bc == 16) dv_st = 4;
            end
            default: ;
         endcase
      end
   end

   // ---------------- scoreboard monitor ----------------
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) chk(1'b0, "R7 unexpected word", 64'(rd_data), 64'hDEAD);
         else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk(rd_data == e, "R7 read word", 64'(rd_data), 64'(e));
         end
      end
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   // ---------------- driver ----------------
   task automatic do_op(input int op, input int addr, input int n, input logic [15:0] wd,
                        input int div, input bit inject);
      int n_eff, exp_bits;
      logic [15:0] exp_cmd;
      n_eff = (n == 0) ? 1 : n;
      @(negedge clk);
      clk_div   = DIV_W'(div);
      cmd_op    = 2'(op);
      cmd_addr  = ADDR_W'(addr);
      cmd_words = CNT_W'(n);
      cmd_wdata = wd;
      cmd_valid = 1'b1;
      if (op == 0) begin
         for (int k = 0; k < n_eff; k++) exp_q.push_back(ref_mem[(addr + k) % 64]);
         exp_cmd  = 16'h0300 | 16'(addr << 1);
         exp_bits = 16 + 16 * n_eff;
      end else if (op == 1) begin
         if (ref_wen) ref_mem[addr] = wd;
         exp_cmd  = 16'h0140 | 16'(addr);
         exp_bits = 32;
      end else begin
         ref_wen  = 1'b1;
         exp_cmd  = 16'h0130;
         exp_bits = 16;
      end
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(busy == 1'b1, "R8 busy after accept", 64'(busy), 64'd1);
      chk(gap_ns >= 20.0 * (div + 1), "R9 cs low gap", 64'(int'(gap_ns)), 64'(20 * (div + 1)));
      if (inject) begin
         repeat (30) @(negedge clk);
         cmd_op = 2'd1; cmd_addr = 6'd9; cmd_wdata = 16'hFFFF; cmd_valid = 1'b1;
         @(negedge clk);
         cmd_valid = 1'b0;
      end
      while (!done) @(negedge clk);
      chk(busy == 1'b0 && mw_cs == 1'b0, "R8 idle at done", {62'd0, busy, mw_cs}, 64'd0);
      chk(period_ns == 20.0 * (div + 1), "R2 sk period", 64'(int'(period_ns)), 64'(20 * (div + 1)));
      chk(rec_n == exp_bits, "R6 clocks in window", 64'(rec_n), 64'(exp_bits));
      if (op == 0) begin
         chk(rec_cmd == exp_cmd, "R3 read command", 64'(rec_cmd), 64'(exp_cmd));
         chk(data_one == 1'b0, "R7 zero data phase", 64'(data_one), 64'd0);
      end else if (op == 1) begin
         chk(rec_cmd == exp_cmd, "R4 write command", 64'(rec_cmd), 64'(exp_cmd));
         chk(rec_bits[15:0] == wd, "R4 write data", 64'(rec_bits[15:0]), 64'(wd));
      end else begin
         chk(rec_cmd == exp_cmd, "R5 enable command", 64'(rec_cmd), 64'(exp_cmd));
      end
      @(negedge clk);
      chk(done == 1'b0, "R8 done pulse", 64'(done), 64'd0);
      chk(exp_q.size() == 0, "R7 word count", 64'(exp_q.size()), 64'd0);
      if (inject) begin
         repeat (20) @(negedge clk);
         chk(busy == 1'b0 && mw_cs == 1'b0, "R10 no late start", {62'd0, busy, mw_cs}, 64'd0);
      end
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin
         dv_mem[i]  = 16'hA500 ^ 16'(i * 16'h0137);
         ref_mem[i] = 16'hA500 ^ 16'(i * 16'h0137);
      end
      repeat (3) @(negedge clk);
      chk({mw_cs, mw_sk, busy, rd_valid, done} == 5'b0, "R1 reset state",
          64'({mw_cs, mw_sk, busy, rd_valid, done}), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({mw_cs, mw_sk, busy, rd_valid, done} == 5'b0, "R1 after reset release",
          64'({mw_cs, mw_sk, busy, rd_valid, done}), 64'd0);

      do_op(0, 0, 1, 16'h0, 1, 1'b0);          // R3 R7 address 0
      do_op(0, 5, 3, 16'h0, 0, 1'b0);          // R7 fastest clock
      do_op(1, 3, 0, 16'h1234, 1, 1'b0);       // R4 before enable: device keeps old word
      do_op(0, 3, 1, 16'h0, 2, 1'b0);          // R7 read back unchanged
      do_op(2, 0, 0, 16'h0, 1, 1'b0);          // R5
      do_op(1, 42, 0, 16'hBEEF, 2, 1'b0);      // R4
      do_op(0, 41, 3, 16'h0, 1, 1'b0);         // R7 run across written word
      do_op(0, 62, 4, 16'h0, 0, 1'b0);         // R7 wrap 63 -> 0
      do_op(0, 7, 0, 16'h0, 1, 1'b0);          // R11 zero count
      do_op(0, 10, 2, 16'h0, 1, 1'b1);         // R10 request while busy
      do_op(0, 20, 15, 16'h0, 3, 1'b0);        // R6 long read, slow clock

      repeat (10) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule